// File: doc/BRIEF.md
# Condition Code and Branch Decision Unit

This block keeps the four status flags produced by the ALU and uses them to decide conditional branches. When the update strobe is high, it loads the flags at the next clock edge from the ALU result word and from the ALU's carry-out and signed-overflow outputs. In every cycle it decodes a four-bit condition selector against the flags it currently holds. The result is a condition-true signal and, for a valid branch request, a program-counter load strobe together with the jump address.

The sixteen selector codes cover four groups: tests of one flag, unsigned magnitude comparisons built from carry and zero, signed two's-complement comparisons built from negative, overflow and zero, and an unconditional code. The decision path is combinational from the held flags. A branch in the same cycle as a flag update therefore sees the flags from before that update.

Top module: `ccb_branch_eval`

## Requirements
- R1: While reset is asserted, and after it is released, `flags_q` reads 0 until the first update.
- R2: At a clock edge where `flag_we` is 1, `flags_q` is loaded as follows. Bit 3 is C, taken from `alu_carry`. Bit 2 is Z, set when `alu_result` is all zeros. Bit 1 is N, taken from the most significant bit of `alu_result`. Bit 0 is V, taken from `alu_ovf`. The new value is visible after that edge.
- R3: At a clock edge where `flag_we` is 0, `flags_q` keeps its value whatever the ALU inputs are.
- R4: Selector codes 0 to 7 test one flag each. The codes are: 0 is C=0, 1 is C=1, 2 is Z=1, 3 is Z=0, 4 is N=1, 5 is N=0, 6 is V=0 and 7 is V=1.
- R5: The unsigned codes are: 8 (higher) is true when C=0 and Z=0, 9 (lower or same) is true when C=1 or Z=1, and 14 (higher or same) is true when C=0.
- R6: The signed codes are: 10 (greater or equal) is true when N equals V, 11 (less than) when N differs from V, 12 (greater than) when N equals V and Z=0, and 13 (less or equal) when Z=1 or N differs from V.
- R7: Code 15 makes `cond_true` 1 for every flag value.
- R8: `cond_true` follows `br_cond` and the held flags in the same cycle. `pc_load` equals `br_valid` AND `cond_true`.
- R9: `pc_target` equals `br_addr` when `pc_load` is 1 and is all zeros otherwise.
- R10: In a cycle where `flag_we` is high, the branch decision before the clock edge uses the flags held before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| flag_we | input | 1 | Flag update strobe |
| alu_result | input | DATA_W | ALU result word |
| alu_carry | input | 1 | ALU carry-out |
| alu_ovf | input | 1 | ALU signed overflow |
| br_valid | input | 1 | A conditional branch is being executed |
| br_cond | input | 4 | Condition selector |
| br_addr | input | ADDR_W | Address field of the branch instruction |
| cond_true | output | 1 | Selected condition holds on the current flags |
| pc_load | output | 1 | Load the program counter with `pc_target` |
| pc_target | output | ADDR_W | Jump address, zero when not loading |
| flags_q | output | 4 | Held flags {C,Z,N,V} |

## Verification
A flag update is due one edge after the cycle that carries the strobe. The decision outputs are combinational on the flags held at the time. The driver changes inputs on the falling edge and pushes one expected item, computed from the flags that will hold after the next rising edge. The monitor pops that item 5 ns after the rising edge, once the new flags and the decision on them have settled. The check for R10 instead samples shortly before the rising edge, while the old flags are still held.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
  } ccb_flags_t;

  typedef enum logic [3:0] {
    CC_CARRY_CLR = 4'd0,
    CC_CARRY_SET = 4'd1,
    CC_EQUAL     = 4'd2,
    CC_NOT_EQUAL = 4'd3,
    CC_MINUS     = 4'd4,
    CC_PLUS      = 4'd5,
    CC_OVF_CLR   = 4'd6,
    CC_OVF_SET   = 4'd7,
    CC_U_HI      = 4'd8,
    CC_U_LS      = 4'd9,
    CC_S_GE      = 4'd10,
    CC_S_LT      = 4'd11,
    CC_S_GT      = 4'd12,
    CC_S_LE      = 4'd13,
    CC_U_HS      = 4'd14,
    CC_ALWAYS    = 4'd15
  } ccb_cond_e;

  // Evaluate one selector against a flag set.
  function automatic logic ccb_eval(input ccb_cond_e sel, input ccb_flags_t f);
    logic sgn_lt;
    sgn_lt = f.n ^ f.v;
    case (sel)
      CC_CARRY_CLR: ccb_eval = ~f.c;
      CC_CARRY_SET: ccb_eval = f.c;
      CC_EQUAL:     ccb_eval = f.z;
      CC_NOT_EQUAL: ccb_eval = ~f.z;
      CC_MINUS:     ccb_eval = f.n;
      CC_PLUS:      ccb_eval = ~f.n;
      CC_OVF_CLR:   ccb_eval = ~f.v;
      CC_OVF_SET:   ccb_eval = f.v;
      CC_U_HI:      ccb_eval = ~(f.c | f.z);
      CC_U_LS:      ccb_eval = f.c | f.z;
      CC_S_GE:      ccb_eval = ~sgn_lt;
      CC_S_LT:      ccb_eval = sgn_lt;
      CC_S_GT:      ccb_eval = ~(sgn_lt | f.z);
      CC_S_LE:      ccb_eval = sgn_lt | f.z;
      CC_U_HS:      ccb_eval = ~f.c;
      default:      ccb_eval = 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/ccb_flag_reg.sv
module ccb_flag_reg
  import ccb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_we,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  output ccb_flags_t        flags
);

  localparam int MSB = DATA_W - 1;

  ccb_flags_t flag_next;
  logic       flag_capture;

  assign flag_capture = flag_we;

  always_comb begin
    flag_next.c = alu_carry;
    flag_next.z = ~|alu_result;
    flag_next.n = alu_result[MSB];
    flag_next.v = alu_ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            flags <= '0;
    else if (flag_capture) flags <= flag_next;
  end

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable(flags));
  p_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags.z == ($past(alu_result) == '0)));
  p_neg_r2: assert property (@(posedge clk) disable iff (!rst_n)
    flag_we |=> (flags.n == $past(alu_result[MSB])));
  p_zn_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(flags.z && flags.n));

endmodule

// File: rtl/ccb_cond_decode.sv
module ccb_cond_decode
  import ccb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [3:0] sel,
  input  ccb_flags_t flags,
  output logic       cond_hit
);

  always_comb cond_hit = ccb_eval(ccb_cond_e'(sel), flags);

  p_always_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'd15) |-> cond_hit);
  p_equal_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'd2) |-> (cond_hit == flags.z));
  p_lt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 4'd11) |-> (cond_hit == (flags.n != flags.v)));

endmodule

// File: rtl/ccb_branch_eval.sv
module ccb_branch_eval
  import ccb_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flag_we,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              br_valid,
  input  logic [3:0]        br_cond,
  input  logic [ADDR_W-1:0] br_addr,
  output logic              cond_true,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_target,
  output logic [3:0]        flags_q
);

  ccb_flags_t flags;
  logic       cond_hit;

  ccb_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_we    (flag_we),
    .alu_result (alu_result),
    .alu_carry  (alu_carry),
    .alu_ovf    (alu_ovf),
    .flags      (flags)
  );

  ccb_cond_decode u_decode (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (br_cond),
    .flags    (flags),
    .cond_hit (cond_hit)
  );

  assign cond_true = cond_hit;
  assign pc_load   = br_valid & cond_hit;
  assign pc_target = pc_load ? br_addr : '0;
  assign flags_q   = flags;

  p_target_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |-> (pc_target == '0));
  p_load_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> (br_valid && pc_target == br_addr));

endmodule

// File: tb/test_ccb_branch_eval.sv
module test_ccb_branch_eval;

  localparam int DATA_W = 16;
  localparam int ADDR_W = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              flag_we = 1'b0;
  logic [DATA_W-1:0] alu_result = '0;
  logic              alu_carry = 1'b0;
  logic              alu_ovf = 1'b0;
  logic              br_valid = 1'b0;
  logic [3:0]        br_cond = '0;
  logic [ADDR_W-1:0] br_addr = '0;
  logic              cond_true, pc_load;
  logic [ADDR_W-1:0] pc_target;
  logic [3:0]        flags_q;

  int errors = 0;
  int checks = 0;

  typedef struct {
    logic [3:0]        flags;
    logic              cond;
    logic              load;
    logic [ADDR_W-1:0] target;
    string             req;
  } exp_t;

  exp_t       sb[$];
  logic [3:0] model = 4'h0;

  always #10 clk = ~clk;

  ccb_branch_eval #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_ccb_branch_eval (
    .clk(clk), .rst_n(rst_n), .flag_we(flag_we), .alu_result(alu_result),
    .alu_carry(alu_carry), .alu_ovf(alu_ovf), .br_valid(br_valid),
    .br_cond(br_cond), .br_addr(br_addr), .cond_true(cond_true),
    .pc_load(pc_load), .pc_target(pc_target), .flags_q(flags_q)
  );

  // Reference decision; flags packed as {C,Z,N,V}.
  function automatic logic ref_cond(input logic [3:0] s, input logic [3:0] f);
    logic c, z, n, v;
    {c, z, n, v} = f;
    if (s == 4'd15) return 1'b1;
    if (s < 4'd8) begin
      logic bitv;
      case (s[2:1])
        2'd0: bitv = c;
        2'd1: bitv = z;
        2'd2: bitv = n;
        default: bitv = v;
      endcase
      // codes 0,6 want the flag clear; 1,7 want it set; 2,4 set; 3,5 clear
      if (s[2:1] == 2'd0 || s[2:1] == 2'd3) return bitv == s[0];
      return bitv == !s[0];
    end
    case (s)
      4'd8:  return (c == 0) && (z == 0);
      4'd9:  return c || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return (n == v) && !z;
      4'd13: return z || (n != v);
      default: return !c;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    if (s < 4'd8) return "R4";
    if (s == 4'd15) return "R7";
    if (s == 4'd8 || s == 4'd9 || s == 4'd14) return "R5";
    return "R6";
  endfunction

  task automatic check(input string req, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic we, input logic [DATA_W-1:0] res,
                       input logic c, input logic v, input logic bv,
                       input logic [3:0] sel, input logic [ADDR_W-1:0] addr,
                       input string req);
    exp_t e;
    @(negedge clk);
    flag_we = we; alu_result = res; alu_carry = c; alu_ovf = v;
    br_valid = bv; br_cond = sel; br_addr = addr;
    if (we) model = {c, (res == 0), res[DATA_W-1], v};
    e.flags  = model;
    e.cond   = ref_cond(sel, model);
    e.load   = bv & e.cond;
    e.target = e.load ? addr : '0;
    e.req    = (req == "") ? req_of(sel) : req;
    sb.push_back(e);
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.req, "flags_q", 16'(flags_q), 16'(e.flags));
        check(e.req, "cond_true", 16'(cond_true), 16'(e.cond));
        check("R8", "pc_load", 16'(pc_load), 16'(e.load));
        check("R9", "pc_target", 16'(pc_target), 16'(e.target));
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (2) @(posedge clk);
    #5 check("R1", "flags_q in reset", 16'(flags_q), 16'h0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk) #5 check("R1", "flags_q after reset", 16'(flags_q), 16'h0);

    // R2, R4-R7: every reachable flag set against every code
    for (int f = 0; f < 16; f++) begin
      logic c, z, n, v;
      logic [DATA_W-1:0] res;
      {c, z, n, v} = 4'(f);
      if (z && n) continue;
      res = z ? '0 : (n ? {1'b1, {(DATA_W-1){1'b0}}} | 16'h0031 : 16'h0420);
      for (int s = 0; s < 16; s++)
        drive(1'b1, res, c, v, 1'b1, 4'(s), ADDR_W'(12'h100 + s), "");
    end

    // R3: hold with strobe low while ALU inputs change
    drive(1'b1, 16'h8001, 1'b1, 1'b0, 1'b0, 4'd0, '0, "R2");
    drive(1'b0, 16'h0000, 1'b0, 1'b1, 1'b1, 4'd4, 12'h3AB, "R3");
    drive(1'b0, 16'h7FFF, 1'b0, 1'b1, 1'b1, 4'd1, 12'h0F0, "R3");

    // R8/R9: no branch request means no load and zero target
    drive(1'b0, 16'h1234, 1'b1, 1'b1, 1'b0, 4'd15, 12'hABC, "R9");

    wait (sb.size() == 0);
    @(negedge clk);

    // R10: same-cycle update and branch decide on the old flags {C=1,Z=0,N=1,V=0}
    flag_we = 1'b1; alu_result = '0; alu_carry = 1'b0; alu_ovf = 1'b0;
    br_valid = 1'b1; br_cond = 4'd2; br_addr = 12'h555;
    #8;
    check("R10", "cond_true before edge", 16'(cond_true), 16'h0);
    check("R10", "pc_load before edge", 16'(pc_load), 16'h0);
    @(posedge clk) #5;
    check("R10", "cond_true after edge", 16'(cond_true), 16'h1);
    check("R10", "pc_target after edge", 16'(pc_target), 16'h555);
    @(negedge clk) flag_we = 1'b0;

    repeat (2) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule